// File: doc/BRIEF.md
# Seven-to-one parallel-load lane serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded clock lane. Each lane carries seven bits per word, so the bit rate is seven times the word rate. The bits are spread over the lanes by a fixed, non-sequential assignment, and each lane emits its seven bits one per bit clock.

The whole block runs on the fast bit clock. The slower word clock is represented by a one-cycle load strobe that arrives every seventh bit clock. A mode input selects one of two capture points:

- **Rising-edge mode:** the word is taken in the strobe cycle itself.
- **Falling-edge mode:** the word is taken four bit clocks later.

Both modes therefore have a fixed, known latency.

The forwarded clock lane runs at the word rate. It is high for four bit slots and low for three. An active-low sleep input clears every register at once and holds all outputs low.

Top module: `lane_serializer7`

## Requirements
- R1: Lane 0 carries word bits 0,1,2,3,4,6,7 in that order. Lane 1 carries 8,9,12,13,14,15,18. Lane 2 carries 19,20,21,22,24,25,26. Lane 3 carries 27,5,10,11,16,17,23. Any word can be rebuilt exactly from the four lanes.
- R2: After a capture, each lane outputs its seven bits on seven consecutive bit clocks, first listed bit first. The first bit appears in the cycle after the capturing edge.
- R3: With `edge_rise`=1, the word present at the edge where `load_stb` is sampled high is the word that gets captured.
- R4: With `edge_rise`=0, the word is captured four edges after the edge where `load_stb` is sampled high.
- R5: During the seven slots that follow a capture, `clk_lane` outputs 1,1,1,1,0,0,0.
- R6: While `sleep_n` is low, `lane_out` and `clk_lane` are 0 immediately, and all internal state is cleared.
- R7: After sleep is released, and after the seventh slot of a word when no new capture has come, all lanes and the clock lane output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| sleep_n | input | 1 | Active-low shutdown and asynchronous clear |
| edge_rise | input | 1 | 1: capture in the strobe cycle; 0: capture four cycles later |
| load_stb | input | 1 | One-cycle word strobe, every seventh bit clock |
| pix_in | input | 28 | Parallel pixel word |
| lane_out | output | 4 | Serial data lanes, one bit per lane |
| clk_lane | output | 1 | Forwarded word clock |

## Verification
A wrong slot counter shows up on the clock lane within one word. It would give a high run other than four, or pulses when the block is idle. A wrong lane register or a wrong entry in the bit assignment shows up in the word rebuilt from the lanes, seven cycles after the capture. A fault in the capture delay shifts the whole lane pattern by whole cycles, and the per-cycle reference model sees this on the first bit of the first word after a mode change. A shutdown that fails to clear shows up as a nonzero lane in the cycle where `sleep_n` falls, or as data after release.

// File: rtl/lane_serializer7.sv
module lane_serializer7 #(
  parameter int FALL_LAG = 4,
  parameter int CLK_HIGH = 4
) (
  input  logic        clk,
  input  logic        sleep_n,
  input  logic        edge_rise,
  input  logic        load_stb,
  input  logic [27:0] pix_in,
  output logic [3:0]  lane_out,
  output logic        clk_lane
);
  localparam int LANES  = 4;
  localparam int SLOTS  = 7;
  localparam int WORD_W = LANES * SLOTS;
  localparam int CW     = $clog2(SLOTS + 1);
  localparam int MAP [WORD_W] = '{0, 1, 2, 3, 4, 6, 7,
                                  8, 9, 12, 13, 14, 15, 18,
                                  19, 20, 21, 22, 24, 25, 26,
                                  27, 5, 10, 11, 16, 17, 23};

  logic [FALL_LAG-1:0] lag;
  logic [CW-1:0]       slot;
  logic                cap;

  assign cap      = edge_rise ? load_stb : lag[FALL_LAG-1];
  assign clk_lane = slot < CW'(CLK_HIGH);

  always_ff @(posedge clk or negedge sleep_n)
    if (!sleep_n) lag <= '0;
    else          lag <= {lag[FALL_LAG-2:0], load_stb};

  always_ff @(posedge clk or negedge sleep_n)
    if (!sleep_n)                slot <= CW'(SLOTS);
    else if (cap)                slot <= '0;
    else if (slot != CW'(SLOTS)) slot <= slot + 1'b1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] fresh, sr;
    for (genvar k = 0; k < SLOTS; k++) begin : g_bit
      assign fresh[SLOTS-1-k] = pix_in[MAP[l*SLOTS+k]];
    end
    always_ff @(posedge clk or negedge sleep_n)
      if (!sleep_n) sr <= '0;
      else if (cap) sr <= fresh;
      else          sr <= {sr[SLOTS-2:0], 1'b0};
    assign lane_out[l] = sr[SLOTS-1];
  end
endmodule

// File: rtl/lane_serializer7_chk.sv
module lane_serializer7_chk (
  input logic        clk,
  input logic        sleep_n,
  input logic        edge_rise,
  input logic        load_stb,
  input logic [27:0] pix_in,
  input logic [3:0]  lane_out,
  input logic        clk_lane
);
  always @(negedge clk)
    if (!sleep_n)
      p_shutdown_quiet_r6: assert (lane_out == 4'b0 && !clk_lane);

  p_rise_capture_r3: assert property (@(posedge clk) disable iff (!sleep_n)
    (edge_rise && load_stb) |=> (clk_lane && lane_out[0] == $past(pix_in[0])));

  p_fall_capture_r4: assert property (@(posedge clk) disable iff (!sleep_n)
    (!edge_rise && $past(!edge_rise, 4) && $past(load_stb, 4) && $past(sleep_n, 1)
     && $past(sleep_n, 2) && $past(sleep_n, 3) && $past(sleep_n, 4))
    |=> (clk_lane && lane_out[0] == $past(pix_in[0])));

  p_clock_high_run_r5: assert property (@(posedge clk) disable iff (!sleep_n)
    $fell(clk_lane) |-> ($past(clk_lane, 2) && $past(clk_lane, 3) && $past(clk_lane, 4)));
endmodule

bind lane_serializer7 lane_serializer7_chk u_chk (.*);

// File: tb/sim_lane_serializer7.sv
module sim_lane_serializer7;
  logic        clk = 1'b0;
  logic        sleep_n = 1'b0;
  logic        edge_rise = 1'b1;
  logic        load_stb = 1'b0;
  logic [27:0] pix_in = '0;
  logic [3:0]  lane_out;
  logic        clk_lane;

  always #10 clk = ~clk;

  lane_serializer7 u0 (.clk(clk), .sleep_n(sleep_n), .edge_rise(edge_rise),
                       .load_stb(load_stb), .pix_in(pix_in),
                       .lane_out(lane_out), .clk_lane(clk_lane));

  int lane_bit [28] = '{0, 1, 2, 3, 4, 6, 7, 8, 9, 12, 13, 14, 15, 18,
                        19, 20, 21, 22, 24, 25, 26, 27, 5, 10, 11, 16, 17, 23};
  int checks = 0, errors = 0;
  string req = "R7";
  bit done = 0;

  int cnt = 7;
  int cyc = 0;
  logic [27:0] mword = '0;
  int due[$];
  logic [27:0] sent[$];
  logic mcap;

  always @(posedge clk or negedge sleep_n) begin
    if (!sleep_n) begin
      cnt = 7;
      due.delete();
    end else begin
      cyc++;
      mcap = 0;
      if (load_stb && !edge_rise) due.push_back(cyc + 4);
      if (load_stb && edge_rise) mcap = 1;
      if (due.size() > 0 && due[0] == cyc) begin
        mcap = 1;
        void'(due.pop_front());
      end
      if (mcap) begin
        mword = pix_in;
        cnt = 0;
      end else if (cnt < 7) cnt++;
    end
  end

  int slot = 99;
  logic prev_clk = 0;
  logic [6:0] got [4];

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] exp_l;
      logic exp_c;
      for (int l = 0; l < 4; l++) exp_l[l] = (cnt < 7) ? mword[lane_bit[l*7+cnt]] : 1'b0;
      exp_c = cnt < 4;
      checks++;
      if (lane_out !== exp_l) begin
        errors++;
        $display("FAIL %s lanes cycle %0d: actual=%b expected=%b", req, cyc, lane_out, exp_l);
      end
      checks++;
      if (clk_lane !== exp_c) begin
        errors++;
        $display("FAIL R5 clock lane cycle %0d: actual=%b expected=%b", cyc, clk_lane, exp_c);
      end
      if (!sleep_n) slot = 99;
      else begin
        if (clk_lane && !prev_clk) slot = 0;
        else if (slot < 7) slot++;
        if (slot < 7)
          for (int l = 0; l < 4; l++) got[l][slot] = lane_out[l];
        if (slot == 6 && sent.size() > 0) begin
          logic [27:0] rebuilt, want;
          for (int l = 0; l < 4; l++)
            for (int k = 0; k < 7; k++) rebuilt[lane_bit[l*7+k]] = got[l][k];
          want = sent.pop_front();
          checks++;
          if (rebuilt !== want) begin
            errors++;
            $display("FAIL R1 rebuilt word: actual=%h expected=%h", rebuilt, want);
          end
        end
      end
      prev_clk = clk_lane;
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic send(input logic [27:0] w);
    step();
    load_stb = 1'b1;
    pix_in = w;
    sent.push_back(w);
    step();
    load_stb = 1'b0;
    repeat (5) step();
  endtask

  task automatic quiet_check(input string tag);
    checks++;
    if (lane_out !== 4'b0 || clk_lane !== 1'b0) begin
      errors++;
      $display("FAIL R6 %s: actual=%b/%b expected=0000/0", tag, lane_out, clk_lane);
    end
  endtask

  task automatic shut_down();
    step();
    sleep_n = 1'b0;
    #1 quiet_check("during shutdown");
    sent.delete();
    repeat (3) step();
    quiet_check("held in shutdown");
  endtask

  initial begin
    repeat (3) step();
    quiet_check("reset state");
    sleep_n = 1'b1;
    req = "R7";
    repeat (6) step();
    req = "R3";
    for (int b = 0; b < 28; b++) send(28'd1 << b);
    send('1);
    send(28'h5555555);
    send(28'hAAAAAAA);
    req = "R2";
    for (int i = 0; i < 15; i++) send(28'($urandom));
    req = "R7";
    repeat (12) step();
    req = "R3";
    step();
    load_stb = 1'b1;
    pix_in = 28'hFFFFFFF;
    step();
    load_stb = 1'b0;
    step();
    step();
    shut_down();
    edge_rise = 1'b0;
    step();
    sleep_n = 1'b1;
    req = "R7";
    repeat (5) step();
    req = "R4";
    for (int i = 0; i < 20; i++) send(28'($urandom));
    send(28'h0000001);
    send(28'h8000000);
    req = "R7";
    repeat (12) step();
    shut_down();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule